// File: doc/BRIEF.md
# Byte/Word Packing Bridge with Aligned Write Addressing

This block moves endpoint payload between a byte-wide data FIFO and a 32-bit system bus master. The data FIFO holds 64 bytes. In the receive direction, a transfer of a given byte count is started with a one-cycle pulse. The block takes bytes one at a time from the data FIFO, packs them into a 32-bit word, and offers each finished word, with its byte enables, to an application-side word FIFO.

In the transmit direction, a transfer of a given word count is started the same way. Each word taken from the application FIFO is cut into four bytes, and the bytes are handed to the data FIFO one per handshake. All FIFO edges use valid/ready signalling. A transfer happens on a clock edge where both valid and ready are high.

A third, independent path turns a byte write address into a bus write. On the cycle after a command, it drives a word-aligned address and a byte-enable mask that covers the addressed byte and every byte above it in that word.

Top module: `byte_word_bridge`

## Requirements
- R1: A synchronous active-high reset returns both directions to idle. While reset is high, and on the first cycle after it, `bf_rd_ready`, `wf_wr_valid`, `wf_rd_ready`, `bf_wr_valid`, `bus_wr_valid`, `rx_busy` and `tx_busy` are all 0.
- R2: Receive packing is little-endian. Byte i of each group of four (i = 0..3, in the order taken) lands in bits 8i+7:8i of `wf_wr_data`. A full word carries `wf_wr_be` = 4'b1111, where bit i qualifies byte lane i.
- R3: If the receive byte count n is not a multiple of 4, the last word holds the remaining r = n mod 4 bytes in lanes 0..r-1. In that word, `wf_wr_be` has only bits 0..r-1 set and the unused lanes read as zero.
- R4: While a packed word waits for `wf_wr_ready`, `wf_wr_valid` stays high, its data and enables stay stable, and no byte is taken from the data FIFO. While `bf_rd_valid` is low, nothing is taken and nothing is lost.
- R5: Transmit unpacking sends the four bytes of each word lowest lane first (bits 7:0 first, bits 31:24 last). Byte output starts on the cycle after a word is taken.
- R6: While `bf_wr_ready` is low, `bf_wr_valid` stays high and `bf_wr_data` stays stable. No byte is skipped or repeated. This holds with a 64-entry data FIFO draining slower than it fills.
- R7: One cycle after `cmd_valid`, `bus_wr_valid` is high, `bus_wr_addr` equals `cmd_addr` with bits 1:0 forced to 0, and `bus_wr_valid` drops one cycle after `cmd_valid` drops.
- R8: For start offset k = `cmd_addr[1:0]`, `bus_wr_be` bit b is set exactly when b >= k. Offset 0 therefore gives 4'b1111 and offset 3 gives 4'b1000.
- R9: A start pulse with a count of zero, or one arriving while that direction is busy, is ignored. The running transfer continues unchanged.
- R10: A receive transfer of n bytes takes exactly n bytes and pushes ceil(n/4) words. A transmit transfer of m words takes exactly m words and emits 4m bytes. Afterwards the direction is idle and takes nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Pulse that starts a receive transfer |
| rx_len | input | LEN_W | Receive byte count, sampled with `rx_start` |
| bf_rd_valid | input | 1 | Data FIFO has a byte to give |
| bf_rd_data | input | 8 | Byte at the head of the data FIFO |
| bf_rd_ready | output | 1 | Bridge takes the head byte this cycle |
| wf_wr_valid | output | 1 | Packed word offered to the application FIFO |
| wf_wr_data | output | 32 | Packed word |
| wf_wr_be | output | 4 | Byte enables of the packed word |
| wf_wr_ready | input | 1 | Application FIFO can accept a word |
| rx_busy | output | 1 | Receive transfer in progress |
| tx_start | input | 1 | Pulse that starts a transmit transfer |
| tx_words | input | WCNT_W | Transmit word count, sampled with `tx_start` |
| wf_rd_valid | input | 1 | Application FIFO has a word to give |
| wf_rd_data | input | 32 | Word at the head of the application FIFO |
| wf_rd_ready | output | 1 | Bridge takes the head word this cycle |
| bf_wr_valid | output | 1 | Byte offered to the data FIFO |
| bf_wr_data | output | 8 | Byte offered |
| bf_wr_ready | input | 1 | Data FIFO can accept a byte |
| tx_busy | output | 1 | Transmit transfer in progress |
| cmd_valid | input | 1 | Write command present |
| cmd_addr | input | ADDR_W | Byte address of the write |
| bus_wr_valid | output | 1 | Aligned bus write present |
| bus_wr_addr | output | ADDR_W | Word-aligned bus address |
| bus_wr_be | output | 4 | Byte enables for the bus write |

## Verification
The bench targets the tail of a receive transfer with lengths 1, 2, 5, 6 and 7. A packer that mishandled the tail would wait forever for a fourth byte, leave stale bytes in unused lanes, or report all four enables. Back-pressure on both FIFOs is exercised with irregular patterns, and a 64-entry data FIFO is filled on transmit. A design that advanced its lane counter or popped during a stall would show up as a skipped, repeated or altered byte. A second start pulse in mid-transfer and a zero-length start check that a restart does not corrupt the counters. All four address offsets are driven, which catches an enable mask that is inverted or shifted the wrong way.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    PK_IDLE    = 2'd0,
    PK_COLLECT = 2'd1,
    PK_PUSH    = 2'd2
  } pk_state_t;

  typedef enum logic [1:0] {
    UP_IDLE  = 2'd0,
    UP_FETCH = 2'd1,
    UP_EMIT  = 2'd2
  } up_state_t;

  // Enable mask for a write that begins at byte offset off within a word.
  function automatic logic [3:0] offset_be(input logic [1:0] off);
    logic [3:0] m;
    m = 4'b1111 << off;
    return m;
  endfunction

  // Extract byte lane 'lane' of a 32-bit word.
  function automatic logic [7:0] pick_byte(input logic [31:0] word,
                                           input logic [1:0]  lane);
    logic [31:0] sh;
    sh = word >> {lane, 3'b000};
    return sh[7:0];
  endfunction

  // Word address with the two offset bits cleared.
  function automatic logic [31:0] align_mask32();
    return 32'hFFFF_FFFC;
  endfunction

endpackage

// File: rtl/bwb_packer.sv
module bwb_packer
  import bwb_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic [3:0]       out_be,
  input  logic             out_ready,
  output logic             busy,
  output logic             byte_take,
  output logic             word_push
);

  pk_state_t        state;
  logic [LEN_W-1:0] remaining;
  logic [1:0]       lane;
  logic [7:0]       slot [LANES];
  logic [LANES-1:0] slot_be;
  logic             last_byte;
  logic             lane_full;

  assign in_ready  = (state == PK_COLLECT);
  assign out_valid = (state == PK_PUSH);
  assign busy      = (state != PK_IDLE);
  assign byte_take = in_ready && in_valid;
  assign word_push = out_valid && out_ready;
  assign last_byte = (remaining == LEN_W'(1));
  assign lane_full = (lane == 2'd3);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          slot[g]    <= 8'h00;
          slot_be[g] <= 1'b0;
        end else if (word_push) begin
          slot[g]    <= 8'h00;
          slot_be[g] <= 1'b0;
        end else if (byte_take && (lane == 2'(g))) begin
          slot[g]    <= in_data;
          slot_be[g] <= 1'b1;
        end
      end
      assign out_data[8*g +: 8] = slot[g];
    end
  endgenerate

  assign out_be = slot_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= PK_IDLE;
      remaining <= '0;
      lane      <= 2'd0;
    end else begin
      case (state)
        PK_IDLE: begin
          if (start && (len != '0)) begin
            state     <= PK_COLLECT;
            remaining <= len;
            lane      <= 2'd0;
          end
        end
        PK_COLLECT: begin
          if (byte_take) begin
            remaining <= remaining - LEN_W'(1);
            lane      <= lane + 2'd1;
            if (lane_full || last_byte) state <= PK_PUSH;
          end
        end
        PK_PUSH: begin
          if (out_ready) begin
            lane  <= 2'd0;
            state <= (remaining == '0) ? PK_IDLE : PK_COLLECT;
          end
        end
        default: state <= PK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bwb_unpacker.sv
module bwb_unpacker
  import bwb_pkg::*;
#(
  parameter int WCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WCNT_W-1:0] nwords,
  input  logic              in_valid,
  input  logic [31:0]       in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic              word_take,
  output logic              byte_put
);

  up_state_t         state;
  logic [31:0]       hold;
  logic [1:0]        lane;
  logic [WCNT_W-1:0] left;

  assign in_ready  = (state == UP_FETCH);
  assign out_valid = (state == UP_EMIT);
  assign busy      = (state != UP_IDLE);
  assign word_take = in_ready && in_valid;
  assign byte_put  = out_valid && out_ready;
  assign out_data  = pick_byte(hold, lane);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= UP_IDLE;
      hold  <= '0;
      lane  <= 2'd0;
      left  <= '0;
    end else begin
      case (state)
        UP_IDLE: begin
          if (start && (nwords != '0)) begin
            state <= UP_FETCH;
            left  <= nwords;
          end
        end
        UP_FETCH: begin
          if (word_take) begin
            hold  <= in_data;
            lane  <= 2'd0;
            state <= UP_EMIT;
          end
        end
        UP_EMIT: begin
          if (byte_put) begin
            lane <= lane + 2'd1;
            if (lane == 2'd3) begin
              left  <= left - WCNT_W'(1);
              state <= (left == WCNT_W'(1)) ? UP_IDLE : UP_FETCH;
            end
          end
        end
        default: state <= UP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bwb_aligner.sv
module bwb_aligner
  import bwb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_be
);

  localparam logic [ADDR_W-1:0] WORD_MASK = {{(ADDR_W-2){1'b1}}, 2'b00};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid <= 1'b0;
      bus_addr  <= '0;
      bus_be    <= 4'b0000;
    end else begin
      bus_valid <= cmd_valid;
      if (cmd_valid) begin
        bus_addr <= cmd_addr & WORD_MASK;
        bus_be   <= offset_be(cmd_addr[1:0]);
      end
    end
  end

endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge #(
  parameter int LEN_W  = 16,
  parameter int WCNT_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_start,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic              bf_rd_valid,
  input  logic [7:0]        bf_rd_data,
  output logic              bf_rd_ready,
  output logic              wf_wr_valid,
  output logic [31:0]       wf_wr_data,
  output logic [3:0]        wf_wr_be,
  input  logic              wf_wr_ready,
  output logic              rx_busy,
  input  logic              tx_start,
  input  logic [WCNT_W-1:0] tx_words,
  input  logic              wf_rd_valid,
  input  logic [31:0]       wf_rd_data,
  output logic              wf_rd_ready,
  output logic              bf_wr_valid,
  output logic [7:0]        bf_wr_data,
  input  logic              bf_wr_ready,
  output logic              tx_busy,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              bus_wr_valid,
  output logic [ADDR_W-1:0] bus_wr_addr,
  output logic [3:0]        bus_wr_be
);

  // Named internal events, observed by the bound checker.
  logic rx_byte_take;
  logic rx_word_push;
  logic tx_word_take;
  logic tx_byte_put;

  bwb_packer #(.LEN_W(LEN_W)) u_packer (
    .clk       (clk),
    .rst       (rst),
    .start     (rx_start),
    .len       (rx_len),
    .in_valid  (bf_rd_valid),
    .in_data   (bf_rd_data),
    .in_ready  (bf_rd_ready),
    .out_valid (wf_wr_valid),
    .out_data  (wf_wr_data),
    .out_be    (wf_wr_be),
    .out_ready (wf_wr_ready),
    .busy      (rx_busy),
    .byte_take (rx_byte_take),
    .word_push (rx_word_push)
  );

  bwb_unpacker #(.WCNT_W(WCNT_W)) u_unpacker (
    .clk       (clk),
    .rst       (rst),
    .start     (tx_start),
    .nwords    (tx_words),
    .in_valid  (wf_rd_valid),
    .in_data   (wf_rd_data),
    .in_ready  (wf_rd_ready),
    .out_valid (bf_wr_valid),
    .out_data  (bf_wr_data),
    .out_ready (bf_wr_ready),
    .busy      (tx_busy),
    .word_take (tx_word_take),
    .byte_put  (tx_byte_put)
  );

  bwb_aligner #(.ADDR_W(ADDR_W)) u_aligner (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_addr  (cmd_addr),
    .bus_valid (bus_wr_valid),
    .bus_addr  (bus_wr_addr),
    .bus_be    (bus_wr_be)
  );

endmodule

// File: rtl/bwb_checker.sv
module bwb_checker #(
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_start,
  input logic [LEN_W-1:0]  rx_len,
  input logic              rx_busy,
  input logic              wf_wr_valid,
  input logic              wf_wr_ready,
  input logic [31:0]       wf_wr_data,
  input logic [3:0]        wf_wr_be,
  input logic              rx_byte_take,
  input logic              tx_word_take,
  input logic              bf_wr_valid,
  input logic              bf_wr_ready,
  input logic [7:0]        bf_wr_data,
  input logic              tx_busy,
  input logic              cmd_valid,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              bus_wr_valid,
  input logic [ADDR_W-1:0] bus_wr_addr,
  input logic [3:0]        bus_wr_be
);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wf_wr_valid && !bf_wr_valid && !bus_wr_valid && !rx_busy && !tx_busy));

  a_r4_word_held: assert property (@(posedge clk) disable iff (rst)
    (wf_wr_valid && !wf_wr_ready) |=>
      (wf_wr_valid && $stable(wf_wr_data) && $stable(wf_wr_be)));

  a_r4_no_take_while_offering: assert property (@(posedge clk) disable iff (rst)
    wf_wr_valid |-> !rx_byte_take);

  a_r3_enables_from_lane0: assert property (@(posedge clk) disable iff (rst)
    wf_wr_valid |-> (wf_wr_be[0] && (((wf_wr_be >> 1) & ~wf_wr_be) == 4'b0000)));

  a_r5_emit_after_take: assert property (@(posedge clk) disable iff (rst)
    tx_word_take |=> bf_wr_valid);

  a_r6_byte_held: assert property (@(posedge clk) disable iff (rst)
    (bf_wr_valid && !bf_wr_ready) |=> (bf_wr_valid && $stable(bf_wr_data)));

  a_r7_aligned: assert property (@(posedge clk) disable iff (rst)
    bus_wr_valid |-> (bus_wr_addr[1:0] == 2'b00));

  a_r7_follows_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (bus_wr_valid && (bus_wr_addr[ADDR_W-1:2] == $past(cmd_addr[ADDR_W-1:2]))));

  a_r8_top_lane_contig: assert property (@(posedge clk) disable iff (rst)
    bus_wr_valid |-> (bus_wr_be[3] && (((bus_wr_be << 1) & ~bus_wr_be) == 4'b0000)));

  a_r9_zero_len_ignored: assert property (@(posedge clk) disable iff (rst)
    (!rx_busy && rx_start && (rx_len == '0)) |=> !rx_busy);

endmodule

bind byte_word_bridge bwb_checker #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_bwb_checker (
  .clk          (clk),
  .rst          (rst),
  .rx_start     (rx_start),
  .rx_len       (rx_len),
  .rx_busy      (rx_busy),
  .wf_wr_valid  (wf_wr_valid),
  .wf_wr_ready  (wf_wr_ready),
  .wf_wr_data   (wf_wr_data),
  .wf_wr_be     (wf_wr_be),
  .rx_byte_take (rx_byte_take),
  .tx_word_take (tx_word_take),
  .bf_wr_valid  (bf_wr_valid),
  .bf_wr_ready  (bf_wr_ready),
  .bf_wr_data   (bf_wr_data),
  .tx_busy      (tx_busy),
  .cmd_valid    (cmd_valid),
  .cmd_addr     (cmd_addr),
  .bus_wr_valid (bus_wr_valid),
  .bus_wr_addr  (bus_wr_addr),
  .bus_wr_be    (bus_wr_be)
);

// File: tb/byte_word_bridge_bench.sv
`timescale 1ns/1ps
module byte_word_bridge_bench;

  localparam int LEN_W  = 16;
  localparam int WCNT_W = 16;
  localparam int ADDR_W = 32;
  localparam int DFIFO_DEPTH = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              rx_start;
  logic [LEN_W-1:0]  rx_len;
  logic              bf_rd_valid;
  logic [7:0]        bf_rd_data;
  logic              bf_rd_ready;
  logic              wf_wr_valid;
  logic [31:0]       wf_wr_data;
  logic [3:0]        wf_wr_be;
  logic              wf_wr_ready;
  logic              rx_busy;
  logic              tx_start;
  logic [WCNT_W-1:0] tx_words;
  logic              wf_rd_valid;
  logic [31:0]       wf_rd_data;
  logic              wf_rd_ready;
  logic              bf_wr_valid;
  logic [7:0]        bf_wr_data;
  logic              bf_wr_ready;
  logic              tx_busy;
  logic              cmd_valid;
  logic [ADDR_W-1:0] cmd_addr;
  logic              bus_wr_valid;
  logic [ADDR_W-1:0] bus_wr_addr;
  logic [3:0]        bus_wr_be;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0]  src_b [0:255];
  logic [31:0] src_w [0:63];

  always #4 clk = ~clk;

  byte_word_bridge #(.LEN_W(LEN_W), .WCNT_W(WCNT_W), .ADDR_W(ADDR_W)) u_byte_word_bridge (
    .clk(clk), .rst(rst),
    .rx_start(rx_start), .rx_len(rx_len),
    .bf_rd_valid(bf_rd_valid), .bf_rd_data(bf_rd_data), .bf_rd_ready(bf_rd_ready),
    .wf_wr_valid(wf_wr_valid), .wf_wr_data(wf_wr_data), .wf_wr_be(wf_wr_be),
    .wf_wr_ready(wf_wr_ready), .rx_busy(rx_busy),
    .tx_start(tx_start), .tx_words(tx_words),
    .wf_rd_valid(wf_rd_valid), .wf_rd_data(wf_rd_data), .wf_rd_ready(wf_rd_ready),
    .bf_wr_valid(bf_wr_valid), .bf_wr_data(bf_wr_data), .bf_wr_ready(bf_wr_ready),
    .tx_busy(tx_busy),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .bus_wr_valid(bus_wr_valid), .bus_wr_addr(bus_wr_addr), .bus_wr_be(bus_wr_be)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_start = 0; rx_len = '0; bf_rd_valid = 0; bf_rd_data = '0; wf_wr_ready = 0;
    tx_start = 0; tx_words = '0; wf_rd_valid = 0; wf_rd_data = '0; bf_wr_ready = 0;
    cmd_valid = 0; cmd_addr = '0;
  endtask

  task automatic test_reset();
    idle_inputs();
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!bf_rd_ready && !wf_wr_valid && !wf_rd_ready && !bf_wr_valid &&
        !bus_wr_valid && !rx_busy && !tx_busy, "R1", "outputs idle after reset",
        {25'd0, bf_rd_ready, wf_wr_valid, wf_rd_ready, bf_wr_valid, bus_wr_valid, rx_busy, tx_busy},
        32'd0);
  endtask

  // Receive: n bytes, optional empty gaps, optional full stalls, optional restart poke.
  task automatic run_rx(input int n, input bit gaps, input bit stall, input int poke);
    int idx = 0;
    int nw = 0;
    int exp_words = (n + 3) / 4;
    bit pend = 0;
    logic [31:0] pdata = '0;
    logic [3:0]  pbe = '0;
    for (int i = 0; i < 256; i++) src_b[i] = 8'((i * 37) + (n * 11) + 5);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (pend) begin
        chk(wf_wr_valid && wf_wr_data == pdata && wf_wr_be == pbe, "R4",
            "word held under back-pressure", wf_wr_data, pdata);
        pend = 0;
      end
      if (nw == exp_words && idx == n && cyc > 2) begin
        idle_inputs();
        break;
      end
      rx_start    = (cyc == 0) || (cyc == poke);
      rx_len      = (cyc == 0) ? LEN_W'(n) : LEN_W'(3);
      bf_rd_valid = (idx < n) && !(gaps && (cyc % 3 == 1));
      bf_rd_data  = src_b[idx % 256];
      wf_wr_ready = !(stall && (cyc % 4 != 3));
      #1;
      if (bf_rd_ready && bf_rd_valid) idx++;
      if (wf_wr_valid && wf_wr_ready) begin
        logic [31:0] ew = '0;
        logic [3:0]  eb = '0;
        for (int b = 0; b < 4; b++) begin
          if (4 * nw + b < n) begin
            ew = ew | ({24'd0, src_b[4 * nw + b]} << (8 * b));
            eb[b] = 1'b1;
          end
        end
        chk(wf_wr_data == ew, (eb == 4'hF) ? "R2" : "R3", "packed word data", wf_wr_data, ew);
        chk(wf_wr_be == eb, (eb == 4'hF) ? "R2" : "R3", "packed word enables",
            {28'd0, wf_wr_be}, {28'd0, eb});
        nw++;
      end else if (wf_wr_valid) begin
        pend = 1; pdata = wf_wr_data; pbe = wf_wr_be;
      end
    end
    chk(idx == n, "R10", "bytes taken", 32'(idx), 32'(n));
    chk(nw == exp_words, "R10", "words pushed", 32'(nw), 32'(exp_words));
    // No further bytes are taken once the transfer has finished.
    bf_rd_valid = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!bf_rd_ready && !rx_busy, "R10", "idle after receive",
          {30'd0, bf_rd_ready, rx_busy}, 32'd0);
    end
    bf_rd_valid = 0;
  endtask

  task automatic test_zero_len();
    @(negedge clk);
    rx_start = 1; rx_len = '0; bf_rd_valid = 1;
    @(negedge clk);
    rx_start = 0;
    for (int k = 0; k < 3; k++) begin
      chk(!rx_busy && !bf_rd_ready, "R9", "zero-length start ignored",
          {30'd0, rx_busy, bf_rd_ready}, 32'd0);
      @(negedge clk);
    end
    bf_rd_valid = 0;
  endtask

  // Transmit: m words into a modelled data FIFO; slow drain forces it full.
  task automatic run_tx(input int m, input bit slow);
    int idx = 0;
    int nb = 0;
    int fcnt = 0;
    bit pend = 0;
    logic [7:0] pdata = '0;
    for (int i = 0; i < 64; i++) src_w[i] = 32'hC0DE_0000 ^ (32'(i) * 32'h0103_0507) ^ 32'(m);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      if (pend) begin
        chk(bf_wr_valid && bf_wr_data == pdata, "R6", "byte held while data FIFO full",
            {24'd0, bf_wr_data}, {24'd0, pdata});
        pend = 0;
      end
      if (nb == 4 * m && cyc > 2) begin
        idle_inputs();
        break;
      end
      if (slow) begin
        if ((cyc % 4 == 0) && fcnt > 0) fcnt--;
      end else begin
        fcnt = 0;
      end
      tx_start    = (cyc == 0);
      tx_words    = WCNT_W'(m);
      wf_rd_valid = (idx < m);
      wf_rd_data  = src_w[idx % 64];
      bf_wr_ready = (fcnt < DFIFO_DEPTH);
      #1;
      if (wf_rd_ready && wf_rd_valid) idx++;
      if (bf_wr_valid && bf_wr_ready) begin
        logic [7:0] eb;
        eb = 8'(src_w[nb / 4] >> (8 * (nb % 4)));
        chk(bf_wr_data == eb, "R5", "unpacked byte order", {24'd0, bf_wr_data}, {24'd0, eb});
        nb++;
        fcnt++;
      end else if (bf_wr_valid) begin
        pend = 1; pdata = bf_wr_data;
      end
    end
    chk(idx == m, "R10", "words taken", 32'(idx), 32'(m));
    chk(nb == 4 * m, "R10", "bytes emitted", 32'(nb), 32'(4 * m));
    wf_rd_valid = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!wf_rd_ready && !tx_busy, "R10", "idle after transmit",
          {30'd0, wf_rd_ready, tx_busy}, 32'd0);
    end
    wf_rd_valid = 0;
  endtask

  task automatic run_align(input logic [31:0] base);
    for (int k = 0; k < 4; k++) begin
      logic [3:0] eb;
      @(negedge clk);
      cmd_valid = 1;
      cmd_addr  = base | 32'(k);
      @(negedge clk);
      cmd_valid = 0;
      for (int b = 0; b < 4; b++) eb[b] = (b >= k);
      chk(bus_wr_valid && bus_wr_addr == (base & ~32'd3), "R7", "aligned address",
          bus_wr_addr, base & ~32'd3);
      chk(bus_wr_be == eb, "R8", "enables from offset", {28'd0, bus_wr_be}, {28'd0, eb});
      @(negedge clk);
      chk(!bus_wr_valid, "R7", "valid drops after command", {31'd0, bus_wr_valid}, 32'd0);
    end
  endtask

  initial begin
    test_reset();
    run_rx(8, 0, 0, -1);   // R2 full words
    run_rx(7, 0, 0, -1);   // R3 three-byte tail
    run_rx(5, 1, 1, -1);   // R4 gaps and full stalls, one-byte tail
    run_rx(1, 0, 1, -1);   // R3 single byte
    run_rx(2, 1, 0, -1);   // R3 two bytes
    run_rx(9, 0, 0, 4);    // R9 restart while busy ignored
    run_rx(6, 1, 1, 7);    // R9 restart under stalls
    test_zero_len();       // R9
    run_tx(3, 0);          // R5
    run_tx(24, 1);         // R6 data FIFO fills
    run_align(32'h1234_5670);
    run_align(32'hFFFF_FFFC);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule